// File: doc/BRIEF.md
# Snapshot Fail Event Counter

This block keeps a 32-bit running total of device-under-test fail events. On every clock cycle a 4-bit fail strobe vector is sampled, one lane per edge strobe. The total grows by the number of lanes that are set, so it can rise by 0 to 4 in a single cycle. A clear input zeroes the total.

A processor reaches the total through a 16-bit register port with two word addresses. Reading the low word returns the live low half. The same read also freezes the full 32-bit total in a snapshot register. The next read of the high word returns the upper half of that snapshot, so the two halves always belong to the same instant. Preloading for diagnostics works the other way round. A low-word write only stages the data. A high-word write then commits both halves to the counter in one cycle.

Top module: `fail_tally`

## Requirements
- R1: After reset the counter, the snapshot register, the staged low word and `rd_data` are all zero.
- R2: In every cycle without clear or high-word write, the counter grows by the number of set bits in `fail_vec` (0 to 4).
- R3: The counter wraps modulo 2^32; 0xFFFFFFFE plus 4 events gives 0x00000002.
- R4: A read with `addr`=0 (low word) drives the counter's low 16 bits, as held before that clock edge, onto `rd_data` one cycle after the strobe. `rd_data` keeps its value in cycles without a read.
- R5: A low-word read copies the whole counter into the snapshot register. A read with `addr`=1 (high word) returns the snapshot's upper 16 bits one cycle later, never the live counter.
- R6: A write with `addr`=0 stores `wr_data` as the staged low word and leaves the counter unchanged.
- R7: A write with `addr`=1 loads the counter with {`wr_data`, staged low word}; fail events in that cycle are discarded.
- R8: `clr` zeroes the counter on the next edge and takes priority over a high-word write and over fail events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Zero the counter |
| fail_vec | input | 4 | Fail strobes, one per edge lane |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 1 | Word select: 0 low, 1 high |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |

## Verification
Counting is driven with single-lane, all-lane, alternating and two-lane strobe vectors. A wrong population count or a dropped lane then shows up as a mismatch in the low word. A preload to 0x0001FFFE followed by all-lane fails between the low read and the high read separates snapshot reads from live reads, because the live upper half has moved to 0x0002 by then. A commit with all four lanes set, a preload near 2^32, and a clear issued together with a high write show the load priority, the wrap and the clear priority.

// File: rtl/fail_tally_pkg.sv
package fail_tally_pkg;
   typedef enum logic {
      SEL_LO = 1'b0,
      SEL_HI = 1'b1
   } word_sel_e;
endpackage

// File: rtl/fail_popcount.sv
module fail_popcount #(
   parameter int LANES = 4,
   parameter int SUM_W = $clog2(LANES + 1)
) (
   input  logic [LANES-1:0] strobe,
   output logic [SUM_W-1:0] total
);
   logic [SUM_W-1:0] partial [LANES+1];

   assign partial[0] = '0;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign partial[i+1] = partial[i] + SUM_W'(strobe[i]);
   end

   assign total = partial[LANES];
endmodule

// File: rtl/fail_accum.sv
module fail_accum #(
   parameter int CNT_W = 32,
   parameter int SUM_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [SUM_W-1:0] inc,
   output logic [CNT_W-1:0] count
);
   if (SUM_W > CNT_W) begin : g_bad_width
      $error("fail_accum: increment wider than counter");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     count <= '0;
      else if (clr)   count <= '0;
      else if (load)  count <= load_val;
      else            count <= count + CNT_W'(inc);
   end
endmodule

// File: rtl/fail_stage.sv
module fail_stage #(
   parameter int CNT_W = 32,
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snap_en,
   input  logic [CNT_W-1:0] live,
   input  logic             stage_en,
   input  logic [BUS_W-1:0] stage_din,
   output logic [CNT_W-1:0] snap,
   output logic [BUS_W-1:0] stage
);
   always_ff @(posedge clk) begin
      if (!rst_n)       snap <= '0;
      else if (snap_en) snap <= live;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        stage <= '0;
      else if (stage_en) stage <= stage_din;
   end
endmodule

// File: rtl/fail_tally.sv
module fail_tally #(
   parameter int LANES = 4,
   parameter int CNT_W = 32,
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [LANES-1:0] fail_vec,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic             addr,
   input  logic [BUS_W-1:0] wr_data,
   output logic [BUS_W-1:0] rd_data
);
   import fail_tally_pkg::*;

   localparam int SUM_W = $clog2(LANES + 1);

   if (CNT_W != 2 * BUS_W) begin : g_bad_split
      $error("fail_tally: counter must be exactly two bus words");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("fail_tally: at least one fail lane required");
   end

   word_sel_e        sel;
   logic             rd_lo, rd_hi, wr_lo, wr_hi;
   logic [SUM_W-1:0] inc;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] snap_q;
   logic [BUS_W-1:0] stage_q;
   logic [BUS_W-1:0] rd_q;

   assign sel   = word_sel_e'(addr);
   assign rd_lo = rd_en && (sel == SEL_LO);
   assign rd_hi = rd_en && (sel == SEL_HI);
   assign wr_lo = wr_en && (sel == SEL_LO);
   assign wr_hi = wr_en && (sel == SEL_HI);

   fail_popcount #(.LANES(LANES), .SUM_W(SUM_W)) u_pop (
      .strobe (fail_vec),
      .total  (inc)
   );

   fail_accum #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .load     (wr_hi),
      .load_val ({wr_data, stage_q}),
      .inc      (inc),
      .count    (count_q)
   );

   fail_stage #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .snap_en   (rd_lo),
      .live      (count_q),
      .stage_en  (wr_lo),
      .stage_din (wr_data),
      .snap      (snap_q),
      .stage     (stage_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_hi) rd_q <= snap_q[CNT_W-1 -: BUS_W];
      else if (rd_lo) rd_q <= count_q[BUS_W-1:0];
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/fail_tally_chk.sv
module fail_tally_chk #(
   parameter int LANES = 4,
   parameter int CNT_W = 32,
   parameter int BUS_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic [LANES-1:0] fail_vec,
   input logic             rd_en,
   input logic             wr_en,
   input logic             addr,
   input logic [BUS_W-1:0] wr_data,
   input logic [BUS_W-1:0] rd_data,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] snap,
   input logic [BUS_W-1:0] stage
);
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(wr_en && addr)) |=>
      count == $past(count) + CNT_W'($countones($past(fail_vec)))); // R2

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0); // R8

   AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr && !clr) |=> count == {$past(wr_data), $past(stage)}); // R7

   AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr) |=> stage == $past(wr_data)); // R6

   AST_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !addr) |=> rd_data == $past(count[BUS_W-1:0])); // R4

   AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !addr) |=> snap == $past(count)); // R5

   AST_HIGH_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr) |=> rd_data == $past(snap[CNT_W-1 -: BUS_W])); // R5

   AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data)); // R4
endmodule

bind fail_tally fail_tally_chk #(.LANES(LANES), .CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .fail_vec (fail_vec),
   .rd_en    (rd_en),
   .wr_en    (wr_en),
   .addr     (addr),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .count    (count_q),
   .snap     (snap_q),
   .stage    (stage_q)
);

// File: tb/tb_fail_tally.sv
`timescale 1ns/1ps
module tb_fail_tally;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic [3:0]  fail_vec = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic        addr = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [31:0] m_cnt = '0;
   logic [31:0] m_snap = '0;
   logic [15:0] m_stage = '0;

   logic [15:0] exp_q [$];
   string       tag_q [$];

   always #2.5 clk = ~clk;

   fail_tally dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .fail_vec(fail_vec),
      .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data)
   );

   // reference model built from the requirements
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= '0; m_snap <= '0; m_stage <= '0;
      end else begin
         if (clr)                m_cnt <= '0;
         else if (wr_en && addr) m_cnt <= {wr_data, m_stage};
         else                    m_cnt <= m_cnt + 32'($countones(fail_vec));
         if (rd_en && !addr) m_snap <= m_cnt;
         if (wr_en && !addr) m_stage <= wr_data;
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic [3:0] f, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         fail_vec = f; rd_en = 0; wr_en = 0; clr = 0;
      end
   endtask

   task automatic rd(input bit hi, input logic [3:0] f, input string tag);
      @(negedge clk);
      fail_vec = f; rd_en = 1; wr_en = 0; clr = 0; addr = hi;
      exp_q.push_back(hi ? m_snap[31:16] : m_cnt[15:0]);
      tag_q.push_back(tag);
   endtask

   task automatic wr(input bit hi, input logic [15:0] d, input logic [3:0] f, input bit c);
      @(negedge clk);
      fail_vec = f; rd_en = 0; wr_en = 1; clr = c; addr = hi; wr_data = d;
   endtask

   // monitor: compare each read result one cycle after its strobe
   initial begin
      forever begin
         @(posedge clk);
         if (rd_en && rst_n) begin
            @(negedge clk);
            if (exp_q.size() == 0) chk("R4 unexpected read", rd_data, 16'hxxxx);
            else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 rd_data after reset", rd_data, 16'h0000);
      rd(0, 4'b0000, "R1 low word after reset");
      rd(1, 4'b0000, "R1 high word after reset");

      // R2: several strobe patterns
      cyc(4'b0001, 3);
      rd(0, 4'b0000, "R2 single lane");
      cyc(4'b1111, 5);
      rd(0, 4'b0000, "R2 all lanes");
      cyc(4'b1010, 4);
      cyc(4'b0110, 2);
      rd(0, 4'b1111, "R2 mixed lanes");
      rd(0, 4'b0000, "R2 read during fails");

      // R4: rd_data holds without a read
      cyc(4'b1111, 1);
      held = rd_data;
      cyc(4'b1111, 4);
      chk("R4 hold without read", rd_data, held);

      // R6: staged low word leaves counter alone
      wr(0, 16'hABCD, 4'b0000, 0);
      rd(0, 4'b0000, "R6 stage no effect");

      // R5: snapshot vs live upper half across a carry
      wr(0, 16'hFFFE, 4'b0000, 0);
      wr(1, 16'h0001, 4'b0000, 0);
      rd(0, 4'b1111, "R5 low of 0001FFFE");
      cyc(4'b1111, 3);
      rd(1, 4'b0000, "R5 high from snapshot");
      rd(0, 4'b0000, "R5 live low after carry");
      rd(1, 4'b0000, "R5 high after new snapshot");

      // R7: commit discards same-cycle fails
      wr(0, 16'h1234, 4'b0000, 0);
      wr(1, 16'h5678, 4'b1111, 0);
      rd(0, 4'b0000, "R7 committed low");
      rd(1, 4'b0000, "R7 committed high");

      // R3: wrap modulo 2^32
      wr(0, 16'hFFFE, 4'b0000, 0);
      wr(1, 16'hFFFF, 4'b0000, 0);
      cyc(4'b1111, 1);
      rd(0, 4'b0000, "R3 wrap low");
      rd(1, 4'b0000, "R3 wrap high");

      // R8: clear beats commit and fails
      cyc(4'b1111, 2);
      wr(0, 16'h9999, 4'b0000, 0);
      wr(1, 16'h7777, 4'b1111, 1);
      rd(0, 4'b0000, "R8 clear low");
      rd(1, 4'b0000, "R8 clear high");

      cyc(4'b0000, 3);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_err++;
         $display("FAIL R4 pending reads actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule